// File: doc/BRIEF.md
# Serial LCD panel power sequencer

This block takes a small serially-controlled LCD controller from cold to lit and back, with no software involvement beyond four request pulses. A prepare request pulses the panel reset line, waits out the settle times and then streams a fixed register script over a three-wire serial link. Each word on that link is nine bits long, and its top bit says whether the low byte is a command or a parameter. Enable, disable and unprepare requests run short phases of their own that switch the backlight and the display and put the panel to sleep.

Every phase is a run of entries in one internal script ROM. An entry is a serial word, a wait of N milliseconds, a reset-line or backlight action, or an end marker. One engine walks the ROM from the entry point of the chosen phase, so a new phase costs ROM entries rather than control logic. The millisecond length and the serial clock rate are parameters.

Top module: `lcd_pwrseq`

## Requirements
- R1: After system reset: lcd_rst_n=1, lcd_cs_n=1, lcd_sclk=0, lcd_sdo=0, lcd_bl_en=0, busy=0, done=0.
- R2: Each serial word is 9 bits, shifted MSB first. Bit 8 is 0 for a command and 1 for a data byte, and bits 7..0 carry the byte. lcd_cs_n is low for exactly one word and high between words. lcd_sclk is low whenever lcd_cs_n is high. lcd_sdo changes only while lcd_sclk is low. Every high phase of lcd_sclk lasts SCLK_HALF clocks.
- R3: Prepare drives lcd_rst_n low for 30 ms, measured as 30*TICKS_PER_MS clocks with at most 8 clocks added, and then drives it high. No word starts within 120 ms of that release.
- R4: The first word of prepare is command 0x11. The next word starts no earlier than 120 ms after this word's lcd_cs_n rises.
- R5: After 0x11, prepare sends exactly 65 more words. In order (C=command, then its data bytes): C36 00; C3A 66; CB2 0C 0C 00 33 33; CB7 35; CBB 2B; CC0 2C; CC2 01; CC3 0F; CC4 20; CC6 0F; CD0 A4 A1; CE0 and 14 gamma bytes; CE1 and 14 gamma bytes; C21; CB0 11 F0; CB1 EE 08 14.
- R6: The gamma bytes after CE0 are D0 0A 0E 08 09 07 2D 33 3D 34 0A 0A 1B 28. Those after CE1 are D0 0A 0F 08 08 07 2E 54 40 34 09 0B 1B 28.
- R7: Enable raises lcd_bl_en before it sends its only word, command 0x29.
- R8: Disable sends its only word, command 0x28, and lowers lcd_bl_en only after that word's lcd_cs_n has risen.
- R9: Unprepare sends exactly one word, command 0x10.
- R10: busy is high from the clock after an accepted request until the phase ends. done is then high for exactly one cycle, and busy is already low in that cycle.
- R11: A request that arrives while busy is high is ignored. It causes no extra word and no backlight change.
- R12: When several requests are high together while idle, only one phase runs. Prepare wins over enable, enable over disable, and disable over unprepare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| req_prepare | input | 1 | Start the power-up and register script |
| req_enable | input | 1 | Start the backlight-on and display-on phase |
| req_disable | input | 1 | Start the display-off and backlight-off phase |
| req_unprepare | input | 1 | Start the sleep-entry phase |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_cs_n | output | 1 | Serial chip select, active low |
| lcd_sclk | output | 1 | Serial clock, idle low |
| lcd_sdo | output | 1 | Serial data to the panel |
| lcd_bl_en | output | 1 | Backlight enable |
| busy | output | 1 | A phase is running |
| done | output | 1 | One-cycle pulse at the end of a phase |

## Verification
The assertions assume that requests are synchronous to clk and are sampled on one edge. The first clean edge after reset may accept a request. The timing properties also assume that SCLK_HALF and TICKS_PER_MS are at least 1. The bench raises each request for exactly one clock, changes it only on falling edges, and raises a request during a running phase only on purpose, to test that it is ignored. It shrinks TICKS_PER_MS so that the millisecond waits stay short while the wait counts in the script keep their real values.

// File: rtl/lcd_pwrseq_pkg.sv
package lcd_pwrseq_pkg;

  typedef enum logic [2:0] {
    K_CMD, K_DAT, K_WAIT, K_RST_ON, K_RST_OFF, K_BL_ON, K_BL_OFF, K_END
  } step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic [7:0]  arg;
  } step_t;

  localparam int IDX_W = 7;
  localparam int WORD_W = 9;

  // Phase entry points inside the script ROM
  localparam logic [IDX_W-1:0] AT_PREPARE   = 7'd0;
  localparam logic [IDX_W-1:0] AT_ENABLE    = 7'd72;
  localparam logic [IDX_W-1:0] AT_DISABLE   = 7'd75;
  localparam logic [IDX_W-1:0] AT_UNPREPARE = 7'd78;

  // Gamma table slots
  localparam logic [IDX_W-1:0] GP_FIRST = 7'd34;
  localparam logic [IDX_W-1:0] GP_LAST  = 7'd47;
  localparam logic [IDX_W-1:0] GN_FIRST = 7'd49;
  localparam logic [IDX_W-1:0] GN_LAST  = 7'd62;

  // Delays in milliseconds
  localparam logic [7:0] MS_RST_HOLD  = 8'd30;
  localparam logic [7:0] MS_RST_SETTLE = 8'd120;
  localparam logic [7:0] MS_WAKE      = 8'd120;

  // Standard display command opcodes
  localparam logic [7:0] OP_SLEEP_IN  = 8'h10;
  localparam logic [7:0] OP_SLEEP_OUT = 8'h11;
  localparam logic [7:0] OP_INVERT_ON = 8'h21;
  localparam logic [7:0] OP_DISP_OFF  = 8'h28;
  localparam logic [7:0] OP_DISP_ON   = 8'h29;
  localparam logic [7:0] OP_ADDR_MODE = 8'h36;
  localparam logic [7:0] OP_PIX_FMT   = 8'h3A;

  function automatic step_t mk(input step_kind_e k, input logic [7:0] a);
    step_t s;
    s.kind = k;
    s.arg  = a;
    return s;
  endfunction

  // Serial word: flag bit 8 set for data, clear for command
  function automatic logic [WORD_W-1:0] word_of(input step_t s);
    return {(s.kind == K_DAT), s.arg};
  endfunction

  // Priority pick: prepare > enable > disable > unprepare
  function automatic logic [IDX_W-1:0] phase_entry(input logic [3:0] r);
    if (r[0])      return AT_PREPARE;
    else if (r[1]) return AT_ENABLE;
    else if (r[2]) return AT_DISABLE;
    else           return AT_UNPREPARE;
  endfunction

  function automatic logic [7:0] gamma_byte(input logic neg, input logic [3:0] k);
    case ({neg, k})
      5'h00: return 8'hD0;  5'h01: return 8'h0A;  5'h02: return 8'h0E;
      5'h03: return 8'h08;  5'h04: return 8'h09;  5'h05: return 8'h07;
      5'h06: return 8'h2D;  5'h07: return 8'h33;  5'h08: return 8'h3D;
      5'h09: return 8'h34;  5'h0A: return 8'h0A;  5'h0B: return 8'h0A;
      5'h0C: return 8'h1B;  5'h0D: return 8'h28;
      5'h10: return 8'hD0;  5'h11: return 8'h0A;  5'h12: return 8'h0F;
      5'h13: return 8'h08;  5'h14: return 8'h08;  5'h15: return 8'h07;
      5'h16: return 8'h2E;  5'h17: return 8'h54;  5'h18: return 8'h40;
      5'h19: return 8'h34;  5'h1A: return 8'h09;  5'h1B: return 8'h0B;
      5'h1C: return 8'h1B;  5'h1D: return 8'h28;
      default: return 8'h00;
    endcase
  endfunction

  function automatic step_t script_step(input logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] off;
    if (i >= GP_FIRST && i <= GP_LAST) begin
      off = i - GP_FIRST;
      return mk(K_DAT, gamma_byte(1'b0, off[3:0]));
    end
    if (i >= GN_FIRST && i <= GN_LAST) begin
      off = i - GN_FIRST;
      return mk(K_DAT, gamma_byte(1'b1, off[3:0]));
    end
    case (i)
      7'd0:  return mk(K_RST_ON,  8'h00);
      7'd1:  return mk(K_WAIT,    MS_RST_HOLD);
      7'd2:  return mk(K_RST_OFF, 8'h00);
      7'd3:  return mk(K_WAIT,    MS_RST_SETTLE);
      7'd4:  return mk(K_CMD,     OP_SLEEP_OUT);
      7'd5:  return mk(K_WAIT,    MS_WAKE);
      7'd6:  return mk(K_CMD, OP_ADDR_MODE);  7'd7:  return mk(K_DAT, 8'h00);
      7'd8:  return mk(K_CMD, OP_PIX_FMT);    7'd9:  return mk(K_DAT, 8'h66);
      7'd10: return mk(K_CMD, 8'hB2);
      7'd11: return mk(K_DAT, 8'h0C);  7'd12: return mk(K_DAT, 8'h0C);
      7'd13: return mk(K_DAT, 8'h00);  7'd14: return mk(K_DAT, 8'h33);
      7'd15: return mk(K_DAT, 8'h33);
      7'd16: return mk(K_CMD, 8'hB7);  7'd17: return mk(K_DAT, 8'h35);
      7'd18: return mk(K_CMD, 8'hBB);  7'd19: return mk(K_DAT, 8'h2B);
      7'd20: return mk(K_CMD, 8'hC0);  7'd21: return mk(K_DAT, 8'h2C);
      7'd22: return mk(K_CMD, 8'hC2);  7'd23: return mk(K_DAT, 8'h01);
      7'd24: return mk(K_CMD, 8'hC3);  7'd25: return mk(K_DAT, 8'h0F);
      7'd26: return mk(K_CMD, 8'hC4);  7'd27: return mk(K_DAT, 8'h20);
      7'd28: return mk(K_CMD, 8'hC6);  7'd29: return mk(K_DAT, 8'h0F);
      7'd30: return mk(K_CMD, 8'hD0);  7'd31: return mk(K_DAT, 8'hA4);
      7'd32: return mk(K_DAT, 8'hA1);
      7'd33: return mk(K_CMD, 8'hE0);
      7'd48: return mk(K_CMD, 8'hE1);
      7'd63: return mk(K_CMD, OP_INVERT_ON);
      7'd64: return mk(K_CMD, 8'hB0);  7'd65: return mk(K_DAT, 8'h11);
      7'd66: return mk(K_DAT, 8'hF0);
      7'd67: return mk(K_CMD, 8'hB1);  7'd68: return mk(K_DAT, 8'hEE);
      7'd69: return mk(K_DAT, 8'h08);  7'd70: return mk(K_DAT, 8'h14);
      7'd71: return mk(K_END, 8'h00);
      7'd72: return mk(K_BL_ON,  8'h00);
      7'd73: return mk(K_CMD,    OP_DISP_ON);
      7'd74: return mk(K_END,    8'h00);
      7'd75: return mk(K_CMD,    OP_DISP_OFF);
      7'd76: return mk(K_BL_OFF, 8'h00);
      7'd77: return mk(K_END,    8'h00);
      7'd78: return mk(K_CMD,    OP_SLEEP_IN);
      default: return mk(K_END,  8'h00);
    endcase
  endfunction

endpackage

// File: rtl/lcd_pwrseq_timer.sv
module lcd_pwrseq_timer #(
  parameter int TICKS_PER_MS = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] ms,
  output logic       expired
);
  localparam int TW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_MS - 1);

  logic          running;
  logic [7:0]    ms_left;
  logic [TW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      ms_left <= '0;
      tick    <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        running <= 1'b1;
        ms_left <= ms;
        tick    <= '0;
      end else if (running) begin
        if (ms_left == 8'd0) begin
          running <= 1'b0;
          expired <= 1'b1;
        end else if (tick == TICK_LAST) begin
          tick    <= '0;
          ms_left <= ms_left - 8'd1;
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_pwrseq_spi9.sv
module lcd_pwrseq_spi9 #(
  parameter int SCLK_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [8:0] word,
  output logic       cs_n,
  output logic       sclk,
  output logic       sdo,
  output logic       busy,
  output logic       sent
);
  localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SCLK_HALF - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_GAP} tx_state_e;
  tx_state_e     state;
  logic [DW-1:0] div;
  logic [8:0]    sh;
  logic [3:0]    bits_left;
  logic          half_end;

  assign half_end = (div == DIV_LAST);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      div       <= '0;
      sh        <= '0;
      bits_left <= '0;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      sdo       <= 1'b0;
      sent      <= 1'b0;
    end else begin
      sent <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cs_n      <= 1'b0;
          sdo       <= word[8];
          sh        <= {word[7:0], 1'b0};
          bits_left <= 4'd8;
          div       <= '0;
          state     <= S_LOW;
        end
        S_LOW: if (half_end) begin
          div   <= '0;
          sclk  <= 1'b1;
          state <= S_HIGH;
        end else div <= div + 1'b1;
        S_HIGH: if (half_end) begin
          div  <= '0;
          sclk <= 1'b0;
          if (bits_left == 4'd0) begin
            cs_n  <= 1'b1;
            state <= S_GAP;
          end else begin
            sdo       <= sh[8];
            sh        <= {sh[7:0], 1'b0};
            bits_left <= bits_left - 4'd1;
            state     <= S_LOW;
          end
        end else div <= div + 1'b1;
        S_GAP: if (half_end) begin
          div   <= '0;
          sent  <= 1'b1;
          state <= S_IDLE;
        end else div <= div + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_pwrseq_engine.sv
module lcd_pwrseq_engine
  import lcd_pwrseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        req,
  input  logic              tx_sent,
  input  logic              tmr_expired,
  output logic              tx_start,
  output logic [WORD_W-1:0] tx_word,
  output logic              tmr_start,
  output logic [7:0]        tmr_ms,
  output logic              lcd_rst_n,
  output logic              bl_en,
  output logic              busy,
  output logic              done,
  output logic              accept
);
  typedef enum logic [1:0] {E_IDLE, E_RUN, E_TX, E_TMR} eng_state_e;
  eng_state_e       state;
  logic [IDX_W-1:0] idx;
  step_t            cur;

  assign cur    = script_step(idx);
  assign accept = (state == E_IDLE) && (|req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= E_IDLE;
      idx       <= '0;
      tx_start  <= 1'b0;
      tx_word   <= '0;
      tmr_start <= 1'b0;
      tmr_ms    <= '0;
      lcd_rst_n <= 1'b1;
      bl_en     <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      tx_start  <= 1'b0;
      tmr_start <= 1'b0;
      done      <= 1'b0;
      case (state)
        E_IDLE: if (accept) begin
          idx   <= phase_entry(req);
          busy  <= 1'b1;
          state <= E_RUN;
        end
        E_RUN: begin
          case (cur.kind)
            K_CMD, K_DAT: begin
              tx_word  <= word_of(cur);
              tx_start <= 1'b1;
              idx      <= idx + 7'd1;
              state    <= E_TX;
            end
            K_WAIT: begin
              tmr_ms    <= cur.arg;
              tmr_start <= 1'b1;
              idx       <= idx + 7'd1;
              state     <= E_TMR;
            end
            K_RST_ON:  begin lcd_rst_n <= 1'b0; idx <= idx + 7'd1; end
            K_RST_OFF: begin lcd_rst_n <= 1'b1; idx <= idx + 7'd1; end
            K_BL_ON:   begin bl_en <= 1'b1;     idx <= idx + 7'd1; end
            K_BL_OFF:  begin bl_en <= 1'b0;     idx <= idx + 7'd1; end
            default: begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= E_IDLE;
            end
          endcase
        end
        E_TX:  if (tx_sent)     state <= E_RUN;
        E_TMR: if (tmr_expired) state <= E_RUN;
        default: state <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_pwrseq.sv
module lcd_pwrseq
  import lcd_pwrseq_pkg::*;
#(
  parameter int TICKS_PER_MS = 100000,
  parameter int SCLK_HALF    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_prepare,
  input  logic req_enable,
  input  logic req_disable,
  input  logic req_unprepare,
  output logic lcd_rst_n,
  output logic lcd_cs_n,
  output logic lcd_sclk,
  output logic lcd_sdo,
  output logic lcd_bl_en,
  output logic busy,
  output logic done
);
  logic              eng_accept;
  logic              tx_start, tx_busy, tx_sent;
  logic [WORD_W-1:0] tx_word;
  logic              tmr_start, tmr_expired;
  logic [7:0]        tmr_ms;

  lcd_pwrseq_engine u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         ({req_unprepare, req_disable, req_enable, req_prepare}),
    .tx_sent     (tx_sent),
    .tmr_expired (tmr_expired),
    .tx_start    (tx_start),
    .tx_word     (tx_word),
    .tmr_start   (tmr_start),
    .tmr_ms      (tmr_ms),
    .lcd_rst_n   (lcd_rst_n),
    .bl_en       (lcd_bl_en),
    .busy        (busy),
    .done        (done),
    .accept      (eng_accept)
  );

  lcd_pwrseq_spi9 #(.SCLK_HALF(SCLK_HALF)) u_spi (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .word  (tx_word),
    .cs_n  (lcd_cs_n),
    .sclk  (lcd_sclk),
    .sdo   (lcd_sdo),
    .busy  (tx_busy),
    .sent  (tx_sent)
  );

  lcd_pwrseq_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .ms      (tmr_ms),
    .expired (tmr_expired)
  );
endmodule

// File: rtl/lcd_pwrseq_checker.sv
module lcd_pwrseq_checker (
  input logic clk,
  input logic rst_n,
  input logic lcd_rst_n,
  input logic lcd_cs_n,
  input logic lcd_sclk,
  input logic lcd_sdo,
  input logic busy,
  input logic done,
  input logic accept,
  input logic tx_start,
  input logic tx_busy
);
  // R2: clock idles low outside a word
  a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_cs_n |-> !lcd_sclk);

  // R2: data holds while the clock is high
  a_r2_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_sclk |-> $stable(lcd_sdo));

  // R2: a new word is launched only into an idle serialiser
  a_r2_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !tx_busy);

  // R3: link silent while the panel is held in reset
  a_r3_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n |-> lcd_cs_n);

  // R10: done only when no longer busy
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: nothing accepted while a phase runs
  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
endmodule

bind lcd_pwrseq lcd_pwrseq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lcd_rst_n (lcd_rst_n),
  .lcd_cs_n  (lcd_cs_n),
  .lcd_sclk  (lcd_sclk),
  .lcd_sdo   (lcd_sdo),
  .busy      (busy),
  .done      (done),
  .accept    (eng_accept),
  .tx_start  (tx_start),
  .tx_busy   (tx_busy)
);

// File: tb/lcd_pwrseq_tb.sv
module lcd_pwrseq_tb;
  localparam int TPM  = 10;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rq_p = 1'b0, rq_e = 1'b0, rq_d = 1'b0, rq_u = 1'b0;
  logic lcd_rst_n, lcd_cs_n, lcd_sclk, lcd_sdo, lcd_bl_en, busy, done;

  lcd_pwrseq #(.TICKS_PER_MS(TPM), .SCLK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_prepare(rq_p), .req_enable(rq_e), .req_disable(rq_d), .req_unprepare(rq_u),
    .lcd_rst_n(lcd_rst_n), .lcd_cs_n(lcd_cs_n), .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo),
    .lcd_bl_en(lcd_bl_en), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Link monitor
  logic [8:0] shreg = '0;
  logic [8:0] cap [0:255];
  int t_fall [0:255];
  int t_rise [0:255];
  int ncap = 0, bits = 0, bit_err = 0, half_err = 0, run = 0;
  int t_rst_fall = 0, t_rst_rise = 0, t_bl_rise = 0, t_bl_fall = 0;

  always @(posedge lcd_sclk) if (rst_n && !lcd_cs_n) begin
    shreg = {shreg[7:0], lcd_sdo};
    bits  = bits + 1;
  end
  always @(negedge lcd_cs_n) if (rst_n) begin
    bits = 0;
    t_fall[ncap & 255] = cyc;
  end
  always @(posedge lcd_cs_n) if (rst_n) begin
    if (bits != 9) bit_err = bit_err + 1;
    cap[ncap & 255]    = shreg;
    t_rise[ncap & 255] = cyc;
    ncap = ncap + 1;
  end
  always @(negedge lcd_rst_n) if (rst_n) t_rst_fall = cyc;
  always @(posedge lcd_rst_n) if (rst_n) t_rst_rise = cyc;
  always @(posedge lcd_bl_en) if (rst_n) t_bl_rise = cyc;
  always @(negedge lcd_bl_en) if (rst_n) t_bl_fall = cyc;
  always @(negedge clk) if (rst_n) begin
    if (lcd_sclk) run = run + 1;
    else begin
      if (run != 0 && run != HALF) half_err = half_err + 1;
      run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_gamma(input int neg, input int k);
    logic [7:0] pos [0:13] = '{8'hD0,8'h0A,8'h0E,8'h08,8'h09,8'h07,8'h2D,
                               8'h33,8'h3D,8'h34,8'h0A,8'h0A,8'h1B,8'h28};
    logic [7:0] ng  [0:13] = '{8'hD0,8'h0A,8'h0F,8'h08,8'h08,8'h07,8'h2E,
                               8'h54,8'h40,8'h34,8'h09,8'h0B,8'h1B,8'h28};
    return (neg != 0) ? ng[k] : pos[k];
  endfunction

  // Expected prepare words after the sleep-exit word (R5, R6)
  function automatic logic [8:0] exp_word(input int i);
    logic [8:0] head [0:27] = '{9'h036,9'h100,9'h03A,9'h166,9'h0B2,9'h10C,9'h10C,
                                9'h100,9'h133,9'h133,9'h0B7,9'h135,9'h0BB,9'h12B,
                                9'h0C0,9'h12C,9'h0C2,9'h101,9'h0C3,9'h10F,9'h0C4,
                                9'h120,9'h0C6,9'h10F,9'h0D0,9'h1A4,9'h1A1,9'h0E0};
    logic [8:0] tail [0:7]  = '{9'h021,9'h0B0,9'h111,9'h1F0,9'h0B1,9'h1EE,9'h108,9'h114};
    if (i <= 28) return head[i-1];
    if (i <= 42) return {1'b1, exp_gamma(0, i-29)};
    if (i == 43) return 9'h0E1;
    if (i <= 57) return {1'b1, exp_gamma(1, i-44)};
    return tail[i-58];
  endfunction

  task automatic pulse(input logic [3:0] r);
    @(negedge clk);
    {rq_u, rq_d, rq_e, rq_p} = r;
    @(negedge clk);
    {rq_u, rq_d, rq_e, rq_p} = 4'b0000;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    chk(!busy, "R10 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R10 done single cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(lcd_rst_n && lcd_cs_n && !lcd_sclk && !lcd_sdo, "R1 link idle",
        {lcd_rst_n, lcd_cs_n, lcd_sclk, lcd_sdo}, 4'b1100);
    chk(!lcd_bl_en && !busy && !done, "R1 status idle", {lcd_bl_en, busy, done}, 0);
  endtask

  task automatic t_prepare();
    ncap = 0;
    pulse(4'b0001);
    chk(busy, "R10 busy after request", busy, 1);
    repeat (40) @(negedge clk);
    pulse(4'b0010);  // R11: ignored while busy
    wait_done();
    chk((t_rst_rise - t_rst_fall) >= 30*TPM && (t_rst_rise - t_rst_fall) <= 30*TPM + 8,
        "R3 reset hold", t_rst_rise - t_rst_fall, 30*TPM);
    chk((t_fall[0] - t_rst_rise) >= 120*TPM, "R3 settle", t_fall[0] - t_rst_rise, 120*TPM);
    chk(cap[0] == 9'h011, "R4 sleep exit", cap[0], 9'h011);
    chk((t_fall[1] - t_rise[0]) >= 120*TPM, "R4 wake wait", t_fall[1] - t_rise[0], 120*TPM);
    chk(ncap == 66, "R5 word count", ncap, 66);
    for (int i = 1; i < 66; i++) begin
      if (i >= 29 && i <= 57 && i != 43)
        chk(cap[i] == exp_word(i), "R6 gamma byte", cap[i], exp_word(i));
      else
        chk(cap[i] == exp_word(i), "R5 script word", cap[i], exp_word(i));
    end
    repeat (50) @(negedge clk);
    chk(!lcd_bl_en && ncap == 66, "R11 request ignored", {lcd_bl_en, ncap[7:0]}, 66);
  endtask

  task automatic t_enable();
    ncap = 0;
    pulse(4'b0010);
    wait_done();
    chk(ncap == 1 && cap[0] == 9'h029, "R7 display on", cap[0], 9'h029);
    chk(lcd_bl_en && t_bl_rise < t_fall[0], "R7 backlight first", t_bl_rise, t_fall[0]);
  endtask

  task automatic t_disable();
    ncap = 0;
    pulse(4'b0100);
    wait_done();
    chk(ncap == 1 && cap[0] == 9'h028, "R8 display off", cap[0], 9'h028);
    chk(!lcd_bl_en && t_bl_fall >= t_rise[0], "R8 backlight last", t_bl_fall, t_rise[0]);
  endtask

  task automatic t_unprepare();
    ncap = 0;
    pulse(4'b1000);
    wait_done();
    chk(ncap == 1 && cap[0] == 9'h010, "R9 sleep in", cap[0], 9'h010);
  endtask

  task automatic t_priority();
    ncap = 0;
    pulse(4'b1110);
    wait_done();
    chk(ncap == 1 && cap[0] == 9'h029 && lcd_bl_en, "R12 enable wins", cap[0], 9'h029);
    ncap = 0;
    pulse(4'b1100);
    wait_done();
    chk(ncap == 1 && cap[0] == 9'h028 && !lcd_bl_en, "R12 disable wins", cap[0], 9'h028);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prepare();
    t_enable();
    t_disable();
    t_unprepare();
    t_priority();
    chk(bit_err == 0, "R2 nine bits per frame", bit_err, 0);
    chk(half_err == 0, "R2 clock high length", half_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule